// File: doc/BRIEF.md
# Frame Scanout Burst Address Generator

This block walks one frame of pixel data held in memory and turns it into a stream of read burst requests. Each request carries a byte address and a beat count. A one-cycle start pulse begins the frame. At that pulse the block captures its whole configuration: the frame's starting byte address, the number of bytes to fetch per line, the byte step from one line to the next, the number of lines minus one, a burst size select and a limit on requests in flight. It then issues requests line by line. It never lets a burst run past the end of a line, and it keeps the number of unanswered requests within the programmed limit.

Requests leave on a valid/ready channel. Each accepted request is later answered by exactly one response, which may carry an error flag. When the last burst of the frame has been issued and every response has come back, the block raises a one-cycle frame-done pulse. An error response raises a one-cycle bus-error pulse, and the frame goes on to its end. The memory, the pixel buffer and the pixel unpacking sit outside this block.

Top module: `fb_scan_agen`

## Requirements
- R1: While reset is held and right after it, `req_valid`, `frame_done` and `bus_err` are low.
- R2: A `frame_start` pulse while idle captures every configuration input. Configuration changes made later, and further `frame_start` pulses before the frame completes, have no effect on the frame in progress.
- R3: Line i (counting from 0) starts at byte address base + i × pitch. Within a line, each burst starts right after the previous one, at the previous address plus its beat count × BEAT_BYTES (8 by default). Addresses wrap modulo 2^AW.
- R4: A frame has `cfg_lines_m1` + 1 lines. Each line is ceil(`cfg_line_bytes` / BEAT_BYTES) beats long, so the total number of requests matches that split exactly.
- R5: The burst select is read as follows: bit k (k = 0..4) selects 2^k beats. When several bits are set, the highest one wins. All zero means single-beat requests.
- R6: Every request asks for 1 to the selected burst size in beats, and never for more beats than remain in the line. The last burst of a line is shortened to fit what is left.
- R7: Requests presented on the channel but not yet answered never exceed the limit field. A field value N from 1 to 15 allows N, and 0 acts as 1.
- R8: Once `req_valid` is high, it stays high with `req_addr` and `req_beats` unchanged until `req_ready` is seen.
- R9: `frame_done` pulses for one cycle, exactly once per frame. The pulse comes in the cycle after the response count of a fully issued frame reaches zero.
- R10: A response with `rsp_err` high produces a one-cycle `bus_err` pulse in the next cycle, and the frame still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame when idle |
| cfg_base | input | AW | Byte address of the first line |
| cfg_line_bytes | input | LW | Bytes fetched per line |
| cfg_pitch | input | AW | Byte step between line starts |
| cfg_lines_m1 | input | CW | Line count minus one |
| cfg_burst_sel | input | 5 | One-hot burst size select |
| cfg_max_outst | input | 4 | Limit on unanswered requests |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | AW | Byte address of the burst |
| req_beats | output | 5 | Beat count of the burst (1..16) |
| rsp_valid | input | 1 | One response for an earlier accepted request |
| rsp_err | input | 1 | Error flag of the response |
| frame_done | output | 1 | Frame fully fetched pulse |
| bus_err | output | 1 | Error response pulse |

## Verification
The assertions take for granted that the memory side returns exactly one response per accepted request and never answers before acceptance, so the in-flight counter cannot underflow. They also assume `cfg_line_bytes` is at least one. The bench responder answers only requests accepted at an earlier clock edge, in order, with random delays and random ready gaps, and every generated line length lies between 1 and 200 bytes. Frames that get a configuration change or a second start pulse partway through are made long enough that they are still running when that happens.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  localparam int BURST_SEL_W = 5;
  localparam int BEATS_W     = 5;
  localparam int OUTST_W     = 4;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_RUN,
    WALK_DRAIN
  } walk_state_e;

  // Highest set select bit wins; an empty select means single beats.
  function automatic logic [BEATS_W-1:0] sel_to_beats(input logic [BURST_SEL_W-1:0] sel);
    logic [BEATS_W-1:0] r;
    r = BEATS_W'(1);
    for (int k = 0; k < BURST_SEL_W; k++) begin
      if (sel[k]) r = BEATS_W'(1) << k;
    end
    return r;
  endfunction

endpackage

// File: rtl/fb_burst_sizer.sv
module fb_burst_sizer
  import fb_scan_pkg::*;
#(
  parameter int REM_W = 14
) (
  input  logic [BEATS_W-1:0] max_beats,
  input  logic [REM_W-1:0]   rem_beats,
  output logic [BEATS_W-1:0] burst_beats
);

  // Clip the burst to what is left of the line.
  always_comb begin
    if (rem_beats < REM_W'(max_beats)) burst_beats = rem_beats[BEATS_W-1:0];
    else                               burst_beats = max_beats;
  end

endmodule

// File: rtl/fb_outst_ctr.sv
module fb_outst_ctr
  import fb_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               dec,
  input  logic [OUTST_W-1:0] limit,
  output logic [OUTST_W-1:0] cnt,
  output logic               full
);

  logic [OUTST_W-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? OUTST_W'(1) : limit;
  assign full    = (cnt >= lim_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + OUTST_W'(1);
        2'b01:   cnt <= cnt - OUTST_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  outst_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim_eff);

  // R7
  outst_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc) |-> (cnt != '0));

endmodule

// File: rtl/fb_line_walker.sv
module fb_line_walker
  import fb_scan_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 12,
  parameter int BEAT_BYTES = 8,
  parameter int BEAT_SH    = $clog2(BEAT_BYTES),
  parameter int REM_W      = LW - BEAT_SH + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic [AW-1:0]          cfg_base,
  input  logic [LW-1:0]          cfg_line_bytes,
  input  logic [AW-1:0]          cfg_pitch,
  input  logic [CW-1:0]          cfg_lines_m1,
  input  logic [BURST_SEL_W-1:0] cfg_burst_sel,
  input  logic [OUTST_W-1:0]     cfg_max_outst,
  input  logic                   req_ready,
  input  logic [OUTST_W-1:0]     outst_cnt,
  input  logic                   outst_full,
  input  logic [BEATS_W-1:0]     burst_beats,
  output logic [BEATS_W-1:0]     max_beats,
  output logic [REM_W-1:0]       rem_beats,
  output logic [OUTST_W-1:0]     limit,
  output logic                   issue,
  output logic                   req_valid,
  output logic [AW-1:0]          req_addr,
  output logic [BEATS_W-1:0]     req_beats,
  output logic                   frame_done
);

  walk_state_e        state_q;
  logic [AW-1:0]      line_addr_q, cur_addr_q, pitch_q;
  logic [REM_W-1:0]   line_beats_q, rem_q;
  logic [CW-1:0]      lines_left_q;
  logic [BEATS_W-1:0] max_beats_q;
  logic [OUTST_W-1:0] limit_q;
  logic               req_valid_q, done_q;
  logic [AW-1:0]      req_addr_q;
  logic [BEATS_W-1:0] req_beats_q;

  logic [LW:0]        bytes_rnd;
  logic [REM_W-1:0]   line_beats_cfg;
  logic [REM_W-1:0]   rem_left;
  logic [AW-1:0]      next_line;
  logic [AW-1:0]      next_cur;

  // Bytes per line rounded up to whole beats.
  assign bytes_rnd      = {1'b0, cfg_line_bytes} + (LW+1)'(BEAT_BYTES - 1);
  assign line_beats_cfg = bytes_rnd[LW:BEAT_SH];

  assign issue     = (state_q == WALK_RUN) && (!req_valid_q || req_ready) && !outst_full;
  assign rem_left  = rem_q - REM_W'(burst_beats);
  assign next_line = line_addr_q + pitch_q;
  assign next_cur  = cur_addr_q + (AW'(burst_beats) << BEAT_SH);

  assign max_beats  = max_beats_q;
  assign rem_beats  = rem_q;
  assign limit      = limit_q;
  assign req_valid  = req_valid_q;
  assign req_addr   = req_addr_q;
  assign req_beats  = req_beats_q;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= WALK_IDLE;
      line_addr_q  <= '0;
      cur_addr_q   <= '0;
      pitch_q      <= '0;
      line_beats_q <= '0;
      rem_q        <= '0;
      lines_left_q <= '0;
      max_beats_q  <= BEATS_W'(1);
      limit_q      <= '0;
      req_valid_q  <= 1'b0;
      req_addr_q   <= '0;
      req_beats_q  <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req_valid_q && req_ready) req_valid_q <= 1'b0;

      case (state_q)
        WALK_IDLE: begin
          if (frame_start) begin
            line_addr_q  <= cfg_base;
            cur_addr_q   <= cfg_base;
            pitch_q      <= cfg_pitch;
            line_beats_q <= line_beats_cfg;
            rem_q        <= line_beats_cfg;
            lines_left_q <= cfg_lines_m1;
            max_beats_q  <= sel_to_beats(cfg_burst_sel);
            limit_q      <= cfg_max_outst;
            state_q      <= WALK_RUN;
          end
        end

        WALK_RUN: begin
          if (issue) begin
            req_valid_q <= 1'b1;
            req_addr_q  <= cur_addr_q;
            req_beats_q <= burst_beats;
            if (rem_left == '0) begin
              if (lines_left_q == '0) begin
                state_q <= WALK_DRAIN;
              end else begin
                line_addr_q  <= next_line;
                cur_addr_q   <= next_line;
                rem_q        <= line_beats_q;
                lines_left_q <= lines_left_q - CW'(1);
              end
            end else begin
              cur_addr_q <= next_cur;
              rem_q      <= rem_left;
            end
          end
        end

        WALK_DRAIN: begin
          if (outst_cnt == '0) begin
            done_q  <= 1'b1;
            state_q <= WALK_IDLE;
          end
        end

        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_q && !req_ready) |=> (req_valid_q && $stable(req_addr_q) && $stable(req_beats_q)));

  // R6
  burst_range_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_q |-> ((req_beats_q != '0) && (req_beats_q <= max_beats_q)));

  // R6
  line_end_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> (REM_W'(burst_beats) <= rem_q));

  // R9
  done_drained_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((outst_cnt == '0) && !req_valid_q));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == WALK_IDLE) |-> !req_valid_q);

endmodule

// File: rtl/fb_scan_agen.sv
module fb_scan_agen
  import fb_scan_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 12,
  parameter int BEAT_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic [AW-1:0]          cfg_base,
  input  logic [LW-1:0]          cfg_line_bytes,
  input  logic [AW-1:0]          cfg_pitch,
  input  logic [CW-1:0]          cfg_lines_m1,
  input  logic [BURST_SEL_W-1:0] cfg_burst_sel,
  input  logic [OUTST_W-1:0]     cfg_max_outst,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [AW-1:0]          req_addr,
  output logic [BEATS_W-1:0]     req_beats,
  input  logic                   rsp_valid,
  input  logic                   rsp_err,
  output logic                   frame_done,
  output logic                   bus_err
);

  localparam int BEAT_SH = $clog2(BEAT_BYTES);
  localparam int REM_W   = LW - BEAT_SH + 1;

  logic [BEATS_W-1:0] max_beats, burst_beats;
  logic [REM_W-1:0]   rem_beats;
  logic [OUTST_W-1:0] limit, outst_cnt;
  logic               outst_full, issue;
  logic               bus_err_q;

  fb_line_walker #(
    .AW(AW), .LW(LW), .CW(CW), .BEAT_BYTES(BEAT_BYTES),
    .BEAT_SH(BEAT_SH), .REM_W(REM_W)
  ) u_walker (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_burst_sel(cfg_burst_sel), .cfg_max_outst(cfg_max_outst),
    .req_ready(req_ready), .outst_cnt(outst_cnt), .outst_full(outst_full),
    .burst_beats(burst_beats), .max_beats(max_beats), .rem_beats(rem_beats),
    .limit(limit), .issue(issue), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .frame_done(frame_done)
  );

  fb_burst_sizer #(.REM_W(REM_W)) u_sizer (
    .max_beats(max_beats), .rem_beats(rem_beats), .burst_beats(burst_beats)
  );

  fb_outst_ctr u_outst (
    .clk(clk), .rst(rst), .inc(issue), .dec(rsp_valid), .limit(limit),
    .cnt(outst_cnt), .full(outst_full)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_err_q <= 1'b0;
    else     bus_err_q <= rsp_valid && rsp_err;
  end

  assign bus_err = bus_err_q;

  // R10
  bus_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |=> bus_err);

endmodule

// File: tb/fb_scan_agen_bench.sv
module fb_scan_agen_bench;

  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = 12;
  localparam int BB = 8;
  localparam int QD = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_line_bytes = '0;
  logic [AW-1:0] cfg_pitch = '0;
  logic [CW-1:0] cfg_lines_m1 = '0;
  logic [4:0]    cfg_burst_sel = '0;
  logic [3:0]    cfg_max_outst = '0;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [4:0]    req_beats;
  logic          rsp_valid, rsp_err;
  logic          frame_done, bus_err;

  always #10 clk = ~clk;

  fb_scan_agen u_fb_scan_agen (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_burst_sel(cfg_burst_sel), .cfg_max_outst(cfg_max_outst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .frame_done(frame_done), .bus_err(bus_err)
  );

  logic [AW-1:0] exp_addr [0:QD-1];
  int            exp_beats[0:QD-1];
  int            acc_cyc  [0:QD-1];
  int exp_n = 0;
  int rdy_pct = 70, rsp_pct = 60, occ_lim = 1;
  bit err_arm = 1'b0;
  int err_at = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int acc_n = 0, rsp_n = 0, cyc = 0, done_cnt = 0, occ_bad = 0, occ_max = 0, err_seen = 0;
  int r_checks = 0, r_errors = 0;

  function automatic int sel_beats(input logic [4:0] s);
    int r;
    r = 1;
    for (int k = 0; k < 5; k++) if (s[k]) r = 1 << k;
    return r;
  endfunction

  // Memory-side model: random ready, in-order responses at least one cycle after acceptance.
  initial begin
    bit            err_prev, hold_prev;
    logic [AW-1:0] addr_prev;
    logic [4:0]    beats_prev;
    int            occ;
    err_prev = 1'b0; hold_prev = 1'b0; addr_prev = '0; beats_prev = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        // R10: error pulse one cycle after an error response
        if (err_prev || bus_err) r_checks++;
        if (bus_err !== err_prev) begin
          r_errors++;
          $display("FAIL R10 bus_err actual %0b expected %0b", bus_err, err_prev);
        end
        if (bus_err) err_seen++;
        // R8: held request stays unchanged
        if (hold_prev) begin
          r_checks++;
          if (!req_valid || req_addr !== addr_prev || req_beats !== beats_prev) begin
            r_errors++;
            $display("FAIL R8 held req actual v%0b %h/%0d expected v1 %h/%0d",
                     req_valid, req_addr, req_beats, addr_prev, beats_prev);
          end
        end
        occ = acc_n - rsp_n + (req_valid ? 1 : 0);
        if (occ > occ_lim) occ_bad++;
        if (occ > occ_max) occ_max = occ;
        if (frame_done) done_cnt++;

        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        if (rsp_n < acc_n && acc_cyc[rsp_n] < cyc && int'($urandom % 100) < rsp_pct) begin
          rsp_valid = 1'b1;
          rsp_err   = err_arm && (rsp_n == err_at);
          rsp_n++;
        end
        err_prev = rsp_valid && rsp_err;

        req_ready = (int'($urandom % 100) < rdy_pct);
        hold_prev = req_valid && !req_ready;
        addr_prev = req_addr;
        beats_prev = req_beats;
        if (req_valid && req_ready && acc_n < QD) begin
          r_checks++;
          // R3 R5 R6: address and beat count of each accepted burst
          if (acc_n >= exp_n) begin
            r_errors++;
            $display("FAIL R4 extra request %0d addr %h actual count %0d expected %0d",
                     acc_n, req_addr, acc_n + 1, exp_n);
          end else if (req_addr !== exp_addr[acc_n] || req_beats !== 5'(exp_beats[acc_n])) begin
            r_errors++;
            $display("FAIL R3 R5 R6 request %0d actual %h/%0d expected %h/%0d",
                     acc_n, req_addr, req_beats, exp_addr[acc_n], exp_beats[acc_n]);
          end
          acc_cyc[acc_n] = cyc;
          acc_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [AW-1:0] base, input int len, input logic [AW-1:0] pitch,
                           input int lm1, input logic [4:0] sel, input int lim,
                           input bit disturb, input bit inject);
    int mb, first, d0, ob0, e0, rem, b;
    logic [AW-1:0] a;
    mb = sel_beats(sel);
    first = exp_n;
    for (int l = 0; l <= lm1; l++) begin
      a = base + AW'(l) * pitch;
      rem = (len + BB - 1) / BB;
      while (rem > 0) begin
        b = (rem < mb) ? rem : mb;
        exp_addr[exp_n]  = a;
        exp_beats[exp_n] = b;
        exp_n++;
        a = a + AW'(b * BB);
        rem = rem - b;
      end
    end
    occ_lim = (lim == 0) ? 1 : lim;
    occ_max = 0;
    err_at  = first + 1;
    err_arm = inject;
    d0 = done_cnt; ob0 = occ_bad; e0 = err_seen;
    cfg_base = base; cfg_line_bytes = LW'(len); cfg_pitch = pitch;
    cfg_lines_m1 = CW'(lm1); cfg_burst_sel = sel; cfg_max_outst = 4'(lim);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      cfg_base = ~base; cfg_pitch = pitch + 64; cfg_line_bytes = LW'(len + 40);
      cfg_burst_sel = 5'b00001; cfg_lines_m1 = CW'(lm1 + 3);
      frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "frame_done pulses", done_cnt - d0, 1);
    chk(acc_n == exp_n, disturb ? "R2" : "R4", "requests in frame", acc_n - first, exp_n - first);
    chk(rsp_n == acc_n, "R9", "responses before done", rsp_n, acc_n);
    chk(occ_bad == ob0, "R7", "in-flight over limit events", occ_bad - ob0, 0);
    chk(req_valid == 1'b0, "R2", "req_valid after frame", int'(req_valid), 0);
    if (inject) chk(err_seen == e0 + 1, "R10", "bus_err pulses", err_seen - e0, 1);
    err_arm = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h0005EED1));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(req_valid == 1'b0, "R1", "req_valid in reset", int'(req_valid), 0);
    chk(frame_done == 1'b0, "R1", "frame_done in reset", int'(frame_done), 0);
    chk(bus_err == 1'b0, "R1", "bus_err in reset", int'(bus_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", int'(req_valid), 0);

    // R5: empty select gives single beats; 3 beats per line, two lines
    run_frame(32'h1000_0000, 24, 32'h40, 1, 5'b00000, 15, 0, 0);
    // R6: 20 beats with 16-beat bursts -> 16 then a shortened 4
    run_frame(32'h2000_0100, 160, 32'h100, 2, 5'b10000, 15, 0, 0);
    // R5: two select bits, highest (4 beats) wins; 50 bytes -> 7 beats -> 4 + 3
    run_frame(32'h3000_0007, 50, 32'h48, 3, 5'b00110, 4, 0, 0);
    // R4: single line of one byte
    run_frame(32'h4000_0000, 1, 32'h8, 0, 5'b01000, 2, 0, 0);
    // R7: limit of one with slow responses
    rsp_pct = 20;
    run_frame(32'h5000_0000, 96, 32'h80, 3, 5'b00010, 1, 0, 0);
    chk(occ_max == 1, "R7", "peak in flight at limit 1", occ_max, 1);
    // R7: limit field zero behaves as one
    run_frame(32'h5100_0000, 64, 32'h40, 2, 5'b00001, 0, 0, 0);
    chk(occ_max == 1, "R7", "peak in flight at limit 0", occ_max, 1);
    rsp_pct = 60;
    // R2: config changes and a second start mid-frame are ignored
    rsp_pct = 30;
    run_frame(32'h6000_0000, 160, 32'h200, 4, 5'b00100, 2, 1, 0);
    rsp_pct = 60;
    // R10: error response mid-frame, frame completes
    run_frame(32'h7000_0000, 128, 32'h80, 2, 5'b00100, 6, 0, 1);
    // R3: wrap past the top of the address space
    run_frame(32'hFFFF_FF80, 64, 32'h60, 3, 5'b00100, 8, 0, 0);

    for (int f = 0; f < 16; f++) begin
      int len, lm1, lim;
      logic [4:0] sel;
      logic [AW-1:0] pitch;
      len   = 1 + int'($urandom % 200);
      pitch = AW'(((len + 7) & ~7) + 8 * int'($urandom % 4));
      lm1   = int'($urandom % 6);
      sel   = ($urandom % 6 == 0) ? 5'b00000 : 5'(1 << ($urandom % 5));
      lim   = int'($urandom % 16);
      rdy_pct = 30 + int'($urandom % 71);
      rsp_pct = 30 + int'($urandom % 71);
      run_frame($urandom, len, pitch, lm1, sel, lim, 0, 0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks + r_checks, errors + r_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog run did not complete actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks + r_checks + 1, errors + r_errors + 1);
      $finish;
    end
  end

endmodule